// File: doc/BRIEF.md
# Shared Memory Access Protection Unit

This block holds the control state that an embedded core and an external host use to share one on-chip memory. The core sets the size of the main memory block, which gives the first address past that block. The core also holds a bank of per-block override bits that can veto host reads. The host read-protect bits arrive from the host-side protection logic. A combinational check port reports whether a host read of a given block is allowed at that moment.

An eight-bit semaphore register carries handshake flags between the two sides. Each side owns one nibble and can read all eight bits. Override bits that fall inside the core or host boot regions are fixed at 1 and cannot be cleared. A change of the main-block size puts every override bit back to its default.

The core reaches its registers through a simple address / write-data / write-enable bus with registered read data. The host has a narrow port that writes its semaphore nibble and reads the whole semaphore. The memory arrays, host bus decoding, boot-size programming and write protection are outside this block.

Top module: `shmem_guard`

## Requirements
- R1: After reset the semaphore is 0x00, every override bit holds its default from R5, and the size field is 0 when `strap_zero_size` is 1 and the parameter `ROM_UNITS` otherwise.
- R2: `main_top` always equals the size field shifted left by 16, which is the size in 64 KB units times 0x10000.
- R3: A core write to the size register (address 0, data bits 4:0) takes effect only when `dev_mode` is 1. When `dev_mode` is 0 the write is ignored.
- R4: Core writes to address 1 change only semaphore bits 7:4, taken from write-data bits 7:4. Host writes change only bits 3:0, taken from `host_sem_wdata`. Neither side can change the other side's nibble. Both sides read all eight bits.
- R5: The override vector has 48 bits. Flat bit i is bit i%16 of override register i/16. Its default is 1 when i < `core_boot_blks` or i >= 48 - `host_boot_blks`, and 0 otherwise.
- R6: Override bits with a default of 1 are read-only. All other override bits take the core write data when their register is written (addresses 2, 3 and 4 for registers 0, 1 and 2).
- R7: An accepted size write whose value differs from the current size reloads every override bit to its R5 default. A write of the same value leaves the override bits unchanged.
- R8: `chk_allow` is 1 only when `chk_blk` is below 48, `host_prot[chk_blk]` is 0 and override bit `chk_blk` is 0.
- R9: `core_rdata` shows the register at `core_addr` one cycle after the address is presented. The size register reads in bits 4:0 and the semaphore in bits 7:0. Addresses 5 to 7 read 0. `host_sem_rdata` shows the semaphore with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| dev_mode | input | 1 | Development mode; enables size writes |
| strap_zero_size | input | 1 | Strap that forces the size reset value to 0 |
| core_boot_blks | input | 6 | Number of core boot blocks, counted from block 0 |
| host_boot_blks | input | 6 | Number of host boot blocks, counted down from the top block |
| core_addr | input | 3 | Core register address |
| core_wdata | input | 16 | Core write data |
| core_we | input | 1 | Core write enable |
| core_rdata | output | 16 | Core read data, registered |
| host_sem_we | input | 1 | Host semaphore write enable |
| host_sem_wdata | input | 4 | Host semaphore nibble |
| host_sem_rdata | output | 8 | Semaphore as seen by the host, registered |
| host_prot | input | 48 | Host read-protect bit per block |
| chk_blk | input | 6 | Block index to check |
| chk_allow | output | 1 | Host read of `chk_blk` is allowed |
| main_top | output | 21 | First address past the main block |

## Verification
Several properties are checked on every cycle. The size field stays still whenever development mode is off. Each semaphore nibble stays still unless its owner writes it. Boot-region override bits stay at 1. A size change is followed by default override values. Unmapped addresses read zero. The read-write pattern of the override bits, the reset value chosen by the strap, the difference between a repeated size value and a new one, and the allow decision over mixed protect and override patterns can only be shown by the bench's directed scenarios.

// File: rtl/shg_pkg.sv
package shg_pkg;
   localparam int ADDR_W     = 3;
   localparam int SEM_W      = 8;
   localparam int SEM_HALF   = SEM_W / 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_SIZE = 3'd0,
      RA_SEM  = 3'd1,
      RA_OVR0 = 3'd2,
      RA_OVR1 = 3'd3,
      RA_OVR2 = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/shg_size_reg.sv
module shg_size_reg #(
   parameter int SIZE_W    = 5,
   parameter int ROM_UNITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_mode,
   input  logic              strap_zero,
   input  logic              wr,
   input  logic [SIZE_W-1:0] wdata,
   output logic [SIZE_W-1:0] size_q,
   output logic              changed
);
   localparam logic [SIZE_W-1:0] ROM_DEF = SIZE_W'(ROM_UNITS);

   generate
      if (SIZE_W < 1 || SIZE_W > 8) begin : g_bad_w
         $error("SIZE_W out of range");
      end
      if (ROM_UNITS < 0 || ROM_UNITS >= (1 << SIZE_W)) begin : g_bad_rom
         $error("ROM_UNITS does not fit SIZE_W");
      end
   endgenerate

   logic accept;
   assign accept  = wr && dev_mode;
   assign changed = accept && (wdata != size_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         size_q <= strap_zero ? '0 : ROM_DEF;
      else if (accept)
         size_q <= wdata;
   end

   // size is locked outside development mode
   assert_size_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_mode |=> $stable(size_q));
endmodule

// File: rtl/shg_semaphore.sv
module shg_semaphore #(
   parameter int  SEM_W       = 8,
   parameter bit  CORE_OWNS_HI = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               core_wr,
   input  logic [SEM_W-1:0]   core_wdata,
   input  logic               host_wr,
   input  logic [SEM_W/2-1:0] host_wdata,
   output logic [SEM_W-1:0]   sem_q
);
   localparam int HALF = SEM_W / 2;

   generate
      if (SEM_W % 2 != 0 || SEM_W < 2) begin : g_bad_w
         $error("SEM_W must be even");
      end
   endgenerate

   logic [HALF-1:0] core_nib, host_nib;
   logic [HALF-1:0] core_src;

   generate
      if (CORE_OWNS_HI) begin : g_core_hi
         assign core_src = core_wdata[SEM_W-1:HALF];
         assign sem_q    = {core_nib, host_nib};
      end else begin : g_core_lo
         assign core_src = core_wdata[HALF-1:0];
         assign sem_q    = {host_nib, core_nib};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       core_nib <= '0;
      else if (core_wr) core_nib <= core_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_nib <= '0;
      else if (host_wr) host_nib <= host_wdata;
   end

   // each nibble moves only on its owner's write
   assert_core_nib_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !core_wr |=> $stable(core_nib));
   assert_host_nib_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable(host_nib));
endmodule

// File: rtl/shg_override_bank.sv
module shg_override_bank #(
   parameter int NREG   = 3,
   parameter int REG_W  = 16,
   parameter int BOOT_W = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BOOT_W-1:0]      core_boot,
   input  logic [BOOT_W-1:0]      host_boot,
   input  logic                   reload,
   input  logic [NREG-1:0]        wr_sel,
   input  logic [REG_W-1:0]       wdata,
   output logic [NREG*REG_W-1:0]  ovr_flat
);
   localparam int NBLK = NREG * REG_W;

   generate
      if ((1 << BOOT_W) <= NBLK) begin : g_bad_boot
         $error("BOOT_W too narrow to count all blocks");
      end
   endgenerate

   logic [NBLK-1:0] boot_mask;

   always_comb begin
      for (int i = 0; i < NBLK; i++)
         boot_mask[i] = (i < int'(core_boot)) || (i >= NBLK - int'(host_boot));
   end

   genvar r;
   generate
      for (r = 0; r < NREG; r++) begin : g_reg
         logic [REG_W-1:0] ro;
         logic [REG_W-1:0] q;
         assign ro = boot_mask[r*REG_W +: REG_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= ro;
            else if (reload)
               q <= ro;
            else if (wr_sel[r])
               q <= (wdata & ~ro) | ro;
         end

         assign ovr_flat[r*REG_W +: REG_W] = q;
      end
   endgenerate

   // boot-region bits never clear
   assert_boot_bits_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flat & boot_mask) == boot_mask);
   // size change restores defaults
   assert_reload_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> ovr_flat == boot_mask);
endmodule

// File: rtl/shmem_guard.sv
module shmem_guard #(
   parameter int SIZE_W    = 5,
   parameter int ROM_UNITS = 4,
   parameter int NREG      = 3,
   parameter int REG_W     = 16,
   parameter int BLK_IDX_W = 6,
   parameter bit CORE_OWNS_HI = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dev_mode,
   input  logic                    strap_zero_size,
   input  logic [BLK_IDX_W-1:0]    core_boot_blks,
   input  logic [BLK_IDX_W-1:0]    host_boot_blks,
   input  logic [2:0]              core_addr,
   input  logic [REG_W-1:0]        core_wdata,
   input  logic                    core_we,
   output logic [REG_W-1:0]        core_rdata,
   input  logic                    host_sem_we,
   input  logic [3:0]              host_sem_wdata,
   output logic [7:0]              host_sem_rdata,
   input  logic [NREG*REG_W-1:0]   host_prot,
   input  logic [BLK_IDX_W-1:0]    chk_blk,
   output logic                    chk_allow,
   output logic [SIZE_W+15:0]      main_top
);
   import shg_pkg::*;

   localparam int NBLK = NREG * REG_W;

   generate
      if (NREG != 3) begin : g_bad_nreg
         $error("address map holds exactly three override registers");
      end
      if (REG_W < SEM_W || REG_W < SIZE_W) begin : g_bad_regw
         $error("REG_W too narrow");
      end
   endgenerate

   logic [SIZE_W-1:0] size_q;
   logic              size_changed;
   logic [SEM_W-1:0]  sem_q;
   logic [NBLK-1:0]   ovr_flat;
   logic              wr_size, wr_sem;
   logic [NREG-1:0]   wr_ovr;
   logic              addr_mapped;

   assign wr_size   = core_we && (core_addr == RA_SIZE);
   assign wr_sem    = core_we && (core_addr == RA_SEM);
   assign wr_ovr[0] = core_we && (core_addr == RA_OVR0);
   assign wr_ovr[1] = core_we && (core_addr == RA_OVR1);
   assign wr_ovr[2] = core_we && (core_addr == RA_OVR2);
   assign addr_mapped = (core_addr <= RA_OVR2);

   shg_size_reg #(.SIZE_W(SIZE_W), .ROM_UNITS(ROM_UNITS)) u_size (
      .clk(clk), .rst_n(rst_n), .dev_mode(dev_mode), .strap_zero(strap_zero_size),
      .wr(wr_size), .wdata(core_wdata[SIZE_W-1:0]),
      .size_q(size_q), .changed(size_changed));

   shg_semaphore #(.SEM_W(SEM_W), .CORE_OWNS_HI(CORE_OWNS_HI)) u_sem (
      .clk(clk), .rst_n(rst_n),
      .core_wr(wr_sem), .core_wdata(core_wdata[SEM_W-1:0]),
      .host_wr(host_sem_we), .host_wdata(host_sem_wdata),
      .sem_q(sem_q));

   shg_override_bank #(.NREG(NREG), .REG_W(REG_W), .BOOT_W(BLK_IDX_W)) u_ovr (
      .clk(clk), .rst_n(rst_n),
      .core_boot(core_boot_blks), .host_boot(host_boot_blks),
      .reload(size_changed), .wr_sel(wr_ovr), .wdata(core_wdata),
      .ovr_flat(ovr_flat));

   assign main_top = {size_q, 16'h0000};

   logic [REG_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (core_addr)
         RA_SIZE: rd_mux = REG_W'(size_q);
         RA_SEM:  rd_mux = REG_W'(sem_q);
         RA_OVR0: rd_mux = ovr_flat[0*REG_W +: REG_W];
         RA_OVR1: rd_mux = ovr_flat[1*REG_W +: REG_W];
         RA_OVR2: rd_mux = ovr_flat[2*REG_W +: REG_W];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_rdata     <= '0;
         host_sem_rdata <= '0;
      end else begin
         core_rdata     <= rd_mux;
         host_sem_rdata <= sem_q;
      end
   end

   logic in_range;
   assign in_range  = int'(chk_blk) < NBLK;
   always_comb begin
      chk_allow = 1'b0;
      if (in_range)
         chk_allow = !host_prot[chk_blk] && !ovr_flat[chk_blk];
   end

   // unmapped addresses return zero on the next cycle
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_mapped |=> core_rdata == '0);
   // never allow outside the block range
   assert_allow_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_allow |-> int'(chk_blk) < NBLK);
endmodule

// File: tb/shmem_guard_tb.sv
module shmem_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_mode = 1'b0;
   logic        strap_zero_size = 1'b0;
   logic [5:0]  core_boot_blks = 6'd3;
   logic [5:0]  host_boot_blks = 6'd5;
   logic [2:0]  core_addr = '0;
   logic [15:0] core_wdata = '0;
   logic        core_we = 1'b0;
   logic [15:0] core_rdata;
   logic        host_sem_we = 1'b0;
   logic [3:0]  host_sem_wdata = '0;
   logic [7:0]  host_sem_rdata;
   logic [47:0] host_prot = '0;
   logic [5:0]  chk_blk = '0;
   logic        chk_allow;
   logic [20:0] main_top;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   shmem_guard u_dut (.*);

   // bench model of default override values (R5)
   function automatic logic [47:0] def_ovr(int cb, int hb);
      logic [47:0] m;
      for (int i = 0; i < 48; i++) m[i] = (i < cb) || (i >= 48 - hb);
      return m;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(logic strap);
      @(negedge clk);
      strap_zero_size = strap;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic core_wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      core_addr = a; core_wdata = d; core_we = 1'b1;
      @(negedge clk);
      core_we = 1'b0;
   endtask

   task automatic core_rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      core_addr = a;
      @(negedge clk);
      d = core_rdata;
   endtask

   task automatic host_wr(logic [3:0] d);
      @(negedge clk);
      host_sem_wdata = d; host_sem_we = 1'b1;
      @(negedge clk);
      host_sem_we = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [15:0] d;
      logic [47:0] m = def_ovr(3, 5);
      do_reset(1'b0);
      core_rd(3'd0, d); check("R1 size reset", d, 16'd4);
      check("R2 top after reset", main_top, 21'h40000);
      core_rd(3'd1, d); check("R1 sem reset", d, 16'h0000);
      core_rd(3'd2, d); check("R1 R5 ovr0 default", d, m[15:0]);
      core_rd(3'd3, d); check("R1 R5 ovr1 default", d, m[31:16]);
      core_rd(3'd4, d); check("R1 R5 ovr2 default", d, m[47:32]);
      @(negedge clk); check("R9 host sem reset", host_sem_rdata, 8'h00);
   endtask

   task automatic t_strap();
      logic [15:0] d;
      do_reset(1'b1);
      core_rd(3'd0, d); check("R1 strap size zero", d, 16'd0);
      check("R2 top zero", main_top, 21'h0);
      do_reset(1'b0);
   endtask

   task automatic t_size_lock();
      logic [15:0] d;
      dev_mode = 1'b0;
      core_wr(3'd2, 16'h00F0);
      core_wr(3'd0, 16'd9);
      core_rd(3'd0, d); check("R3 size locked", d, 16'd4);
      core_rd(3'd2, d); check("R3 no reload when locked", d, 16'h00F7);
   endtask

   task automatic t_size_write_reload();
      logic [15:0] d;
      dev_mode = 1'b1;
      core_wr(3'd3, 16'h1234);
      core_wr(3'd0, 16'd4);
      core_rd(3'd3, d); check("R7 same size keeps ovr", d, 16'h1234);
      core_wr(3'd0, 16'd9);
      core_rd(3'd0, d); check("R3 size written", d, 16'd9);
      check("R2 top 9", main_top, 21'h90000);
      core_rd(3'd3, d); check("R7 reload ovr1", d, 16'h0000);
      core_rd(3'd2, d); check("R7 reload ovr0", d, 16'h0007);
      core_wr(3'd0, 16'd31);
      check("R2 top 31", main_top, 21'h1F0000);
      dev_mode = 1'b0;
   endtask

   task automatic t_ovr_rw();
      logic [15:0] d;
      core_wr(3'd2, 16'h0000);
      core_rd(3'd2, d); check("R6 ovr0 boot bits stay", d, 16'h0007);
      core_wr(3'd2, 16'hFFFF);
      core_rd(3'd2, d); check("R6 ovr0 all set", d, 16'hFFFF);
      core_wr(3'd4, 16'h0000);
      core_rd(3'd4, d); check("R6 ovr2 host boot stay", d, 16'hF800);
      core_wr(3'd4, 16'h00A5);
      core_rd(3'd4, d); check("R6 ovr2 write", d, 16'hF8A5);
      core_wr(3'd2, 16'h0000);
   endtask

   task automatic t_sem();
      logic [15:0] d;
      core_wr(3'd1, 16'h00FF);
      core_rd(3'd1, d); check("R4 core writes hi only", d, 16'h00F0);
      host_wr(4'hA);
      core_rd(3'd1, d); check("R4 host nibble seen by core", d, 16'h00FA);
      check("R9 host sem read", host_sem_rdata, 8'hFA);
      core_wr(3'd1, 16'h0030);
      @(negedge clk); check("R4 core keeps host nibble", host_sem_rdata, 8'h3A);
      host_wr(4'h5);
      @(negedge clk); check("R4 host keeps core nibble", host_sem_rdata, 8'h35);
   endtask

   task automatic t_read_map();
      logic [15:0] d;
      core_rd(3'd5, d); check("R9 addr5 zero", d, 16'h0);
      core_rd(3'd7, d); check("R9 addr7 zero", d, 16'h0);
      // latency: data reflects the address of the previous edge only
      @(negedge clk); core_addr = 3'd1;
      @(negedge clk); core_addr = 3'd6;
      check("R9 one cycle latency", core_rdata, 16'h0035);
      @(negedge clk); check("R9 follows new addr", core_rdata, 16'h0);
   endtask

   task automatic t_check();
      host_prot = '0;
      @(negedge clk); chk_blk = 6'd10; #1;
      check("R8 allow clear block", chk_allow, 1'b1);
      chk_blk = 6'd1; #1;
      check("R8 deny core boot", chk_allow, 1'b0);
      chk_blk = 6'd45; #1;
      check("R8 deny host boot", chk_allow, 1'b0);
      chk_blk = 6'd32; #1;
      check("R8 deny override set", chk_allow, 1'b0);
      chk_blk = 6'd33; #1;
      check("R8 allow override clear", chk_allow, 1'b1);
      host_prot[33] = 1'b1; #1;
      check("R8 deny host protect", chk_allow, 1'b0);
      chk_blk = 6'd50; host_prot = '0; #1;
      check("R8 deny out of range", chk_allow, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_strap();
      t_size_lock();
      t_size_write_reload();
      t_ovr_rw();
      t_sem();
      t_read_map();
      t_check();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule